// File: doc/BRIEF.md
# Vector Instruction Prefix Decoder

This block sits in an instruction decode pipe and takes instruction bytes one per cycle over a valid/ready handshake. It assumes 64-bit mode and a stream that begins directly at the vector prefix, with no legacy prefixes in front. A lead byte of C4h opens the long (three-byte) prefix form, and C5h opens the short (two-byte) form. Any other byte that arrives while the block is waiting is consumed and dropped. After the prefix bytes the block captures the opcode byte and the ModR/M byte. It then presents the decoded register-extension bits, opcode map, W, the extra source register, vector length, implied SIMD prefix code, opcode and ModR/M, together with an undefined-opcode flag.

The caller looks up the opcode it has just sent and presents a 6-bit attribute word while the ModR/M byte is being transferred. The attribute bits are:
- [5:4] length rule: 0 = length ignored, 1 = length must be zero, 2 = 128-bit only, 3 = 256-bit only.
- [3:2] W rule: 0 = ignored, 1 = W must be 0, 2 = W must be 1, 3 = ignored.
- [1] the vvvv field names an operand.
- [0] a register-select immediate follows.

When bit [0] is set, the byte after ModR/M is taken as that immediate. The caller supplies it directly, because SIB and displacement bytes are not parsed here.

The state machine has these states:
- IDLE waits for a lead byte.
- V3_P1 and V3_P2 take the two payload bytes of the long form.
- V2_P1 takes the single payload byte of the short form.
- OPC takes the opcode byte.
- MRM takes the ModR/M byte and samples the attribute word.
- IMM takes the immediate.
- DONE holds the results for one cycle.

The transitions are:
- IDLE→V3_P1 on C4h, IDLE→V2_P1 on C5h, and IDLE→IDLE on any other byte.
- V3_P1→V3_P2→OPC for the long form, and V2_P1→OPC for the short form.
- OPC→MRM.
- MRM→IMM when the attribute asks for an immediate, and MRM→DONE otherwise.
- IMM→DONE.
- DONE→IDLE unconditionally.

Top module: `vexd_top`

## Requirements
- R1: A byte of C4h accepted in IDLE starts the three-byte form, and C5h starts the two-byte form. Any other byte accepted in IDLE is dropped and produces no result.
- R2: In the three-byte form, payload byte 1 holds inverted R, X, B in bits [7:5] and the map in [4:0]. Payload byte 2 holds W in [7], inverted vvvv in [6:3], L in [2] and pp in [1:0]. The outputs carry the true (re-inverted) R, X, B and vvvv values.
- R3: In the two-byte form, the payload byte holds inverted R in [7], inverted vvvv in [6:3], L in [2] and pp in [1:0]. The map output is forced to 1 (the 0F map), W to 0, X and B to 0, and `three_byte` is 0.
- R4: `simd_pfx` carries pp unchanged: 00 means none, 01 means 66h, 10 means F3h and 11 means F2h.
- R5: In the three-byte form, a map value other than 1 (0F), 2 (0F38) or 3 (0F3A) sets `ud`.
- R6: When attribute bit [1] is 0, a true vvvv other than 0000 (encoded value other than 1111b) sets `ud`.
- R7: The length rule applies as follows. Rule 0 never faults. Rules 1 and 2 set `ud` when L=1. Rule 3 sets `ud` when L=0.
- R8: The W rule applies as follows. Rule 1 sets `ud` when W=1, and rule 2 sets `ud` when W=0. Because of this, a W-must-be-1 opcode in the two-byte form always sets `ud`. Rules 0 and 3 never fault.
- R9: When attribute bit [0] is 1, the byte after ModR/M is accepted and `is4_reg` = imm[7:4], `is4_pay` = imm[3:0]. Otherwise both outputs are 0.
- R10: `done` is high for exactly one cycle after the last byte of an instruction is accepted. During that cycle `in_ready` is low, and all outputs and `ud` are valid. The block then returns to IDLE.
- R11: A synchronous reset returns the block to IDLE with `done` low and `in_ready` high, and discards any partly received prefix.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Byte offered |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Byte can be taken this cycle |
| in_attr | input | 6 | Opcode attribute word, sampled with the ModR/M byte |
| done | output | 1 | Decoded instruction valid (one cycle) |
| ud | output | 1 | Illegal encoding |
| three_byte | output | 1 | 1 for the long prefix form |
| ext_r | output | 1 | True R extension bit |
| ext_x | output | 1 | True X extension bit |
| ext_b | output | 1 | True B extension bit |
| map_sel | output | 5 | Opcode map field |
| vex_w | output | 1 | W bit |
| vreg | output | 4 | True vvvv register index |
| vlen | output | 1 | L bit |
| simd_pfx | output | 2 | Implied SIMD prefix code |
| opcode | output | 8 | Opcode byte |
| modrm | output | 8 | ModR/M byte |
| is4_reg | output | 4 | Register index from the immediate |
| is4_pay | output | 4 | Payload nibble from the immediate |

## Verification
The assertions assume that the reset is held over the first clock edge, and that `done` is judged only from the port values the block itself registers. They place no demand on how the upstream side paces `in_valid`. The checks on the attribute word assume it is held steady while ModR/M is offered. The stimulus meets this by setting the attribute before the first byte of each instruction and changing it only after that instruction's `done`. Bytes are driven between clock edges and held until the block accepts them, so the queued expectations always line up with the order of the results.

// File: rtl/vexd_pkg.sv
package vexd_pkg;

    localparam int BYTE_W = 8;
    localparam int MAP_W  = 5;
    localparam int REG_W  = 4;
    localparam int PP_W   = 2;
    localparam int ATTR_W = 6;

    localparam logic [BYTE_W-1:0] LEAD_LONG  = 8'hC4;
    localparam logic [BYTE_W-1:0] LEAD_SHORT = 8'hC5;

    localparam logic [MAP_W-1:0] MAP_0F   = 5'd1;
    localparam logic [MAP_W-1:0] MAP_0F38 = 5'd2;
    localparam logic [MAP_W-1:0] MAP_0F3A = 5'd3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_V3_P1,
        ST_V3_P2,
        ST_V2_P1,
        ST_OPC,
        ST_MRM,
        ST_IMM,
        ST_DONE
    } vexd_state_e;

    typedef enum logic [1:0] {
        LR_IGN  = 2'd0,
        LR_ZERO = 2'd1,
        LR_128  = 2'd2,
        LR_256  = 2'd3
    } lrule_e;

    typedef enum logic [1:0] {
        WR_IGN = 2'd0,
        WR_0   = 2'd1,
        WR_1   = 2'd2,
        WR_ANY = 2'd3
    } wrule_e;

    typedef struct packed {
        lrule_e lrule;
        wrule_e wrule;
        logic   vvvv_used;
        logic   has_is4;
    } vexd_attr_t;

endpackage

// File: rtl/vexd_fsm.sv
module vexd_fsm
    import vexd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              attr_is4,
    output vexd_state_e       state,
    output logic              take,
    output logic              in_ready,
    output logic              done
);

    vexd_state_e nxt;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (take && in_byte == LEAD_LONG)       nxt = ST_V3_P1;
                else if (take && in_byte == LEAD_SHORT) nxt = ST_V2_P1;
            end
            ST_V3_P1: if (take) nxt = ST_V3_P2;
            ST_V3_P2: if (take) nxt = ST_OPC;
            ST_V2_P1: if (take) nxt = ST_OPC;
            ST_OPC:   if (take) nxt = ST_MRM;
            ST_MRM:   if (take) nxt = attr_is4 ? ST_IMM : ST_DONE;
            ST_IMM:   if (take) nxt = ST_DONE;
            ST_DONE:  nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        in_ready = (state != ST_DONE);
        take     = in_valid && in_ready;
        done     = (state == ST_DONE);
    end

endmodule

// File: rtl/vexd_fields.sv
module vexd_fields
    import vexd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  vexd_state_e       state,
    input  logic              take,
    input  logic [BYTE_W-1:0] in_byte,
    input  vexd_attr_t        attr_in,
    output logic              three_q,
    output logic              r_t,
    output logic              x_t,
    output logic              b_t,
    output logic [MAP_W-1:0]  map_q,
    output logic              w_q,
    output logic [REG_W-1:0]  vreg_t,
    output logic              l_q,
    output logic [PP_W-1:0]   pp_q,
    output logic [BYTE_W-1:0] opc_q,
    output logic [BYTE_W-1:0] mrm_q,
    output logic [BYTE_W-1:0] imm_q,
    output vexd_attr_t        attr_q
);

    logic             r_n, x_n, b_n;
    logic [REG_W-1:0] vv_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            three_q <= 1'b0;
            r_n     <= 1'b1;
            x_n     <= 1'b1;
            b_n     <= 1'b1;
            map_q   <= MAP_0F;
            w_q     <= 1'b0;
            vv_n    <= '1;
            l_q     <= 1'b0;
            pp_q    <= '0;
            opc_q   <= '0;
            mrm_q   <= '0;
            imm_q   <= '0;
            attr_q  <= '0;
        end else if (take) begin
            case (state)
                ST_IDLE: imm_q <= '0;
                ST_V3_P1: begin
                    three_q <= 1'b1;
                    r_n     <= in_byte[7];
                    x_n     <= in_byte[6];
                    b_n     <= in_byte[5];
                    map_q   <= in_byte[MAP_W-1:0];
                end
                ST_V3_P2: begin
                    w_q  <= in_byte[7];
                    vv_n <= in_byte[6:3];
                    l_q  <= in_byte[2];
                    pp_q <= in_byte[1:0];
                end
                ST_V2_P1: begin
                    three_q <= 1'b0;
                    r_n     <= in_byte[7];
                    x_n     <= 1'b1;
                    b_n     <= 1'b1;
                    map_q   <= MAP_0F;
                    w_q     <= 1'b0;
                    vv_n    <= in_byte[6:3];
                    l_q     <= in_byte[2];
                    pp_q    <= in_byte[1:0];
                end
                ST_OPC: opc_q <= in_byte;
                ST_MRM: begin
                    mrm_q  <= in_byte;
                    attr_q <= attr_in;
                end
                ST_IMM: imm_q <= in_byte;
                default: ;
            endcase
        end
    end

    assign r_t    = ~r_n;
    assign x_t    = ~x_n;
    assign b_t    = ~b_n;
    assign vreg_t = ~vv_n;

endmodule

// File: rtl/vexd_legal.sv
module vexd_legal
    import vexd_pkg::*;
(
    input  logic             three,
    input  logic [MAP_W-1:0] map_sel,
    input  logic             w,
    input  logic [REG_W-1:0] vreg,
    input  logic             l,
    input  vexd_attr_t       attr,
    output logic             ud
);

    logic map_bad, v_bad, l_bad, w_bad;

    always_comb begin
        map_bad = three && !(map_sel inside {MAP_0F, MAP_0F38, MAP_0F3A});
        v_bad   = !attr.vvvv_used && (vreg != '0);
        unique case (attr.lrule)
            LR_IGN:         l_bad = 1'b0;
            LR_ZERO, LR_128: l_bad = l;
            LR_256:         l_bad = !l;
        endcase
        unique case (attr.wrule)
            WR_0:           w_bad = w;
            WR_1:           w_bad = !w || !three;
            WR_IGN, WR_ANY: w_bad = 1'b0;
        endcase
        ud = map_bad | v_bad | l_bad | w_bad;
    end

endmodule

// File: rtl/vexd_top.sv
module vexd_top
    import vexd_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [7:0]  in_byte,
    output logic        in_ready,
    input  logic [5:0]  in_attr,
    output logic        done,
    output logic        ud,
    output logic        three_byte,
    output logic        ext_r,
    output logic        ext_x,
    output logic        ext_b,
    output logic [4:0]  map_sel,
    output logic        vex_w,
    output logic [3:0]  vreg,
    output logic        vlen,
    output logic [1:0]  simd_pfx,
    output logic [7:0]  opcode,
    output logic [7:0]  modrm,
    output logic [3:0]  is4_reg,
    output logic [3:0]  is4_pay
);

    vexd_state_e       state;
    logic              take;
    vexd_attr_t        attr_now, attr_q;
    logic [BYTE_W-1:0] imm_q;

    assign attr_now = vexd_attr_t'(in_attr);

    vexd_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_byte  (in_byte),
        .attr_is4 (attr_now.has_is4),
        .state    (state),
        .take     (take),
        .in_ready (in_ready),
        .done     (done)
    );

    vexd_fields u_fields (
        .clk     (clk),
        .rst     (rst),
        .state   (state),
        .take    (take),
        .in_byte (in_byte),
        .attr_in (attr_now),
        .three_q (three_byte),
        .r_t     (ext_r),
        .x_t     (ext_x),
        .b_t     (ext_b),
        .map_q   (map_sel),
        .w_q     (vex_w),
        .vreg_t  (vreg),
        .l_q     (vlen),
        .pp_q    (simd_pfx),
        .opc_q   (opcode),
        .mrm_q   (modrm),
        .imm_q   (imm_q),
        .attr_q  (attr_q)
    );

    vexd_legal u_legal (
        .three   (three_byte),
        .map_sel (map_sel),
        .w       (vex_w),
        .vreg    (vreg),
        .l       (vlen),
        .attr    (attr_q),
        .ud      (ud)
    );

    assign is4_reg = attr_q.has_is4 ? imm_q[7:4] : 4'd0;
    assign is4_pay = attr_q.has_is4 ? imm_q[3:0] : 4'd0;

endmodule

// File: rtl/vexd_sva.sv
module vexd_sva (
    input logic       clk,
    input logic       rst,
    input logic       in_ready,
    input logic       done,
    input logic       ud,
    input logic       three_byte,
    input logic       ext_x,
    input logic       ext_b,
    input logic [4:0] map_sel,
    input logic       vex_w
);

    p_busy_in_done_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> !in_ready);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_short_defaults_r3: assert property (@(posedge clk) disable iff (rst)
        (done && !three_byte) |-> (map_sel == 5'd1 && !vex_w && !ext_x && !ext_b));

    p_bad_map_r5: assert property (@(posedge clk) disable iff (rst)
        (done && three_byte && (map_sel == 5'd0 || map_sel > 5'd3)) |-> ud);

    p_reset_idle_r11: assert property (@(posedge clk)
        rst |=> (!done && in_ready));

endmodule

bind vexd_top vexd_sva u_sva (
    .clk        (clk),
    .rst        (rst),
    .in_ready   (in_ready),
    .done       (done),
    .ud         (ud),
    .three_byte (three_byte),
    .ext_x      (ext_x),
    .ext_b      (ext_b),
    .map_sel    (map_sel),
    .vex_w      (vex_w)
);

// File: tb/sim_vexd_top.sv
`timescale 1ns/1ps
module sim_vexd_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic [5:0] in_attr = 6'h00;
    logic       in_ready, done, ud, three_byte, ext_r, ext_x, ext_b, vex_w, vlen;
    logic [4:0] map_sel;
    logic [3:0] vreg, is4_reg, is4_pay;
    logic [1:0] simd_pfx;
    logic [7:0] opcode, modrm;

    always #2 clk = ~clk;

    vexd_top u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
        .in_ready(in_ready), .in_attr(in_attr), .done(done), .ud(ud),
        .three_byte(three_byte), .ext_r(ext_r), .ext_x(ext_x), .ext_b(ext_b),
        .map_sel(map_sel), .vex_w(vex_w), .vreg(vreg), .vlen(vlen),
        .simd_pfx(simd_pfx), .opcode(opcode), .modrm(modrm),
        .is4_reg(is4_reg), .is4_pay(is4_pay)
    );

    typedef struct packed {
        logic       ud;
        logic       three;
        logic       r, x, b;
        logic [4:0] map;
        logic       w;
        logic [3:0] v;
        logic       l;
        logic [1:0] pp;
        logic [7:0] opc, mrm;
        logic [3:0] ireg, ipay;
    } exp_t;

    exp_t  q[$];
    string tq[$];
    int    n_tests = 0;
    int    n_fail  = 0;
    bit    prev_done = 1'b0;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    task automatic send(input logic [7:0] b);
        bit acc;
        do begin
            @(negedge clk);
            in_valid = 1'b1;
            in_byte  = b;
            acc      = in_ready;
            @(posedge clk);
        end while (!acc);
    endtask

    task automatic idle_bus();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // attribute: [5:4] length rule, [3:2] W rule, [1] vvvv used, [0] immediate follows
    task automatic run_instr(input bit three, input logic [7:0] p1, input logic [7:0] p2,
                             input logic [7:0] opc, input logic [7:0] mrm,
                             input logic [5:0] attr, input logic [7:0] imm,
                             input string tag);
        exp_t e;
        if (three) begin
            e.r = ~p1[7]; e.x = ~p1[6]; e.b = ~p1[5]; e.map = p1[4:0];
            e.w = p2[7]; e.v = ~p2[6:3]; e.l = p2[2]; e.pp = p2[1:0];
        end else begin
            e.r = ~p1[7]; e.x = 1'b0; e.b = 1'b0; e.map = 5'd1;
            e.w = 1'b0; e.v = ~p1[6:3]; e.l = p1[2]; e.pp = p1[1:0];
        end
        e.three = three;
        e.opc   = opc;
        e.mrm   = mrm;
        e.ireg  = attr[0] ? imm[7:4] : 4'd0;
        e.ipay  = attr[0] ? imm[3:0] : 4'd0;
        e.ud = (three && !(e.map inside {5'd1, 5'd2, 5'd3}))
             || (!attr[1] && e.v != 4'd0)
             || ((attr[5:4] == 2'd1 || attr[5:4] == 2'd2) && e.l)
             || (attr[5:4] == 2'd3 && !e.l)
             || (attr[3:2] == 2'd1 && e.w)
             || (attr[3:2] == 2'd2 && !e.w);
        q.push_back(e);
        tq.push_back(tag);
        @(negedge clk);
        in_attr = attr;
        send(three ? 8'hC4 : 8'hC5);
        send(p1);
        if (three) send(p2);
        send(opc);
        send(mrm);
        if (attr[0]) send(imm);
        idle_bus();
    endtask

    // monitor: compare each result against the queued expectation
    always @(negedge clk) begin
        if (!rst) begin
            if (done && prev_done)
                check(1'b0, "R10", "done longer than one cycle", 64'd1, 64'd0);
            if (done) begin
                check(!in_ready, "R10", "in_ready during done", 64'(in_ready), 64'd0);
                if (q.size() == 0) begin
                    check(1'b0, "R1", "unexpected result", 64'd1, 64'd0);
                end else begin
                    exp_t  e;
                    exp_t  a;
                    string t;
                    e = q.pop_front();
                    t = tq.pop_front();
                    a.ud = ud; a.three = three_byte; a.r = ext_r; a.x = ext_x; a.b = ext_b;
                    a.map = map_sel; a.w = vex_w; a.v = vreg; a.l = vlen; a.pp = simd_pfx;
                    a.opc = opcode; a.mrm = modrm; a.ireg = is4_reg; a.ipay = is4_pay;
                    check(a == e, t, "decoded fields", 64'(a), 64'(e));
                end
            end
        end
        prev_done = done;
    end

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "R10", "watchdog expired", 64'd0, 64'd1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(in_ready && !done, "R11", "state after reset", {62'd0, in_ready, done}, 64'd2);

        // R2 field extraction, long form
        run_instr(1, 8'hE1, 8'h78, 8'h58, 8'hC1, 6'b00_00_0_0, 8'h00, "R2");
        run_instr(1, 8'h02, 8'hC5, 8'h59, 8'hD3, 6'b00_10_1_0, 8'h00, "R2");
        // R5 map legality
        run_instr(1, 8'hE0, 8'h78, 8'h10, 8'hC0, 6'b00_00_0_0, 8'h00, "R5");
        run_instr(1, 8'hE4, 8'h78, 8'h10, 8'hC0, 6'b00_00_0_0, 8'h00, "R5");
        run_instr(1, 8'hFF, 8'h78, 8'h10, 8'hC0, 6'b00_00_0_0, 8'h00, "R5");
        run_instr(1, 8'hE3, 8'h78, 8'h10, 8'hC0, 6'b00_00_0_0, 8'h00, "R5");
        // R3 short form defaults
        run_instr(0, 8'h7D, 8'h00, 8'h28, 8'hC8, 6'b00_00_0_0, 8'h00, "R3");
        // R4 pp codes
        run_instr(0, 8'hF8, 8'h00, 8'h51, 8'hC1, 6'b00_00_0_0, 8'h00, "R4");
        run_instr(0, 8'hF9, 8'h00, 8'h51, 8'hC1, 6'b00_00_0_0, 8'h00, "R4");
        run_instr(0, 8'hFA, 8'h00, 8'h51, 8'hC1, 6'b00_00_0_0, 8'h00, "R4");
        run_instr(0, 8'hFB, 8'h00, 8'h51, 8'hC1, 6'b00_00_0_0, 8'h00, "R4");
        // R6 vvvv unused
        run_instr(1, 8'hE1, 8'h38, 8'h6F, 8'hC1, 6'b00_00_0_0, 8'h00, "R6");
        run_instr(1, 8'hE1, 8'h38, 8'h6F, 8'hC1, 6'b00_00_1_0, 8'h00, "R6");
        // R7 length rules
        run_instr(1, 8'hE1, 8'h7C, 8'h77, 8'hC0, 6'b01_00_0_0, 8'h00, "R7");
        run_instr(1, 8'hE1, 8'h78, 8'h77, 8'hC0, 6'b01_00_0_0, 8'h00, "R7");
        run_instr(1, 8'hE1, 8'h7C, 8'h12, 8'hC0, 6'b10_00_0_0, 8'h00, "R7");
        run_instr(1, 8'hE1, 8'h78, 8'h19, 8'hC0, 6'b11_00_0_0, 8'h00, "R7");
        run_instr(1, 8'hE1, 8'h7C, 8'h19, 8'hC0, 6'b11_00_0_0, 8'h00, "R7");
        run_instr(0, 8'hFC, 8'h00, 8'h58, 8'hC0, 6'b00_00_0_0, 8'h00, "R7");
        // R8 W rules
        run_instr(1, 8'hE2, 8'hF8, 8'h90, 8'hC0, 6'b00_01_0_0, 8'h00, "R8");
        run_instr(1, 8'hE2, 8'h78, 8'h90, 8'hC0, 6'b00_10_0_0, 8'h00, "R8");
        run_instr(0, 8'hF8, 8'h00, 8'h90, 8'hC0, 6'b00_10_0_0, 8'h00, "R8");
        run_instr(1, 8'hE2, 8'hF8, 8'h90, 8'hC0, 6'b00_00_0_0, 8'h00, "R8");
        // R9 register-select immediate
        run_instr(1, 8'hE3, 8'h45, 8'h4B, 8'hC2, 6'b00_01_1_1, 8'hA5, "R9");
        run_instr(0, 8'h49, 8'h00, 8'h4B, 8'hD7, 6'b00_00_1_0, 8'h00, "R9");
        // R1 stray byte in idle is dropped
        send(8'h62);
        idle_bus();
        run_instr(1, 8'h61, 8'h70, 8'hAA, 8'h55, 6'b00_00_1_0, 8'h00, "R1");
        // R11 reset in the middle of a prefix
        send(8'hC4);
        send(8'hE1);
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(in_ready && !done, "R11", "state after mid-prefix reset",
              {62'd0, in_ready, done}, 64'd2);
        run_instr(0, 8'hF8, 8'h00, 8'h10, 8'h11, 6'b00_00_0_0, 8'h00, "R11");

        repeat (5) @(negedge clk);
        check(q.size() == 0, "R10", "results still pending", 64'(q.size()), 64'd0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule